// File: doc/BRIEF.md
# DMA Channel Pending and Activity Tracker

This block keeps two per-channel flag words for a 32-channel DMA controller. The first word marks channels that have been requested and are waiting for service. The second word marks channels that are currently bound to one of the two transfer FIFOs. Request strobes from software and hardware set the waiting flags. Completion events clear them, at frame or at block granularity chosen per channel. A rewrite of a channel's control packet, a bus error or a parity error on that channel also clears its waiting flag.

The arbiter, the FIFO datapath and the bus master sit outside this block and reach it only as single-cycle event inputs. An assign event names a channel. The block binds that channel to the lowest-numbered free FIFO and remembers which FIFO holds it. A release event names a FIFO and frees whichever channel that FIFO holds. Both words are read-only and change one clock after the event that causes the change.

Top module: `dma_chan_track`

## Requirements
- R1: After synchronous reset `pend_word`, `stat_word` and `assign_reject` are all zero.
- R2: A waiting flag is set one cycle after `sw_req[n]` with `sw_en[n]` high, or after `hw_req[n]` with `hw_en[n]` high. A request whose enable is low has no effect.
- R3: Once set, a waiting flag stays set when `sw_en` and `hw_en` drop, until a clear event occurs.
- R4: `ttype[n]`=0 makes flag n clear on `frame_done[n]`, and `block_done[n]` is then ignored. `ttype[n]`=1 makes it clear on `block_done[n]`, and `frame_done[n]` is then ignored.
- R5: `pkt_wr[n]` clears a set waiting flag n. On a clear flag it has no effect.
- R6: `bus_err[n]` or `par_err[n]` clears waiting flag n.
- R7: When a request and a clear event for the same channel arrive in the same cycle, the flag is 0 afterwards.
- R8: An accepted `asg_valid` with channel `asg_chan` binds that channel to the lowest-index free FIFO. Status bit `asg_chan` is 1 on the next cycle.
- R9: No more than two status bits are ever 1. An assign while both FIFOs are busy leaves `stat_word` unchanged and pulses `assign_reject` high for exactly one cycle.
- R10: `rel[f]` clears the status bit of the channel held by FIFO f (bit 0 = FIFO 0, bit 1 = FIFO 1).
- R11: While `glb_en` is 0 or `emu_mode` is 1, the status bits already set hold. A new assign is ignored and does not raise `assign_reject`. Releases still take effect.
- R12: An assign naming a channel that is already bound is ignored and does not raise `assign_reject`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_req | input | 32 | Software request strobe per channel |
| hw_req | input | 32 | Hardware request strobe per channel |
| sw_en | input | 32 | Software request enable per channel |
| hw_en | input | 32 | Hardware request enable per channel |
| ttype | input | 32 | Completion granularity per channel: 0 frame, 1 block |
| frame_done | input | 32 | End-of-frame event per channel |
| block_done | input | 32 | End-of-block event per channel |
| pkt_wr | input | 32 | Control-packet write strobe per channel |
| bus_err | input | 32 | Bus error event per channel |
| par_err | input | 32 | Transaction parity error event per channel |
| glb_en | input | 1 | Global DMA enable |
| emu_mode | input | 1 | Emulation halt active |
| asg_valid | input | 1 | FIFO assign event |
| asg_chan | input | 5 | Channel named by the assign event |
| rel | input | 2 | FIFO release event, one bit per FIFO |
| pend_word | output | 32 | Waiting flags, bit n = channel n |
| stat_word | output | 32 | In-service flags, bit n = channel n |
| assign_reject | output | 1 | One-cycle pulse: assign refused because both FIFOs busy |

## Verification
The waiting flags are driven through a table of single-channel steps. The steps set a flag from each request source with its enable on and off, then clear it with every kind of event, under both completion settings. Each step checks the whole word, so a disturbance on any other channel also shows up. Pairing the non-matching completion event with each setting separates a correct granularity select from one that clears on either event. Putting a request and a clear in the same cycle fixes the priority. The FIFO binding is tested with a fill to capacity, an overflow assign, out-of-order releases and a duplicate assign. The releases show which FIFO each channel actually landed in. Halted assigns show that the halt holds state without flagging an error.

// File: rtl/dma_trk_pkg.sv
package dma_trk_pkg;

    localparam int unsigned NCH   = 32;
    localparam int unsigned NFIFO = 2;
    localparam int unsigned CHW   = $clog2(NCH);
    localparam int unsigned FW    = (NFIFO > 1) ? $clog2(NFIFO) : 1;

    // Completion granularity that clears a waiting flag
    typedef enum logic {
        TT_FRAME = 1'b0,
        TT_BLOCK = 1'b1
    } ttype_e;

    // One FIFO's binding record
    typedef struct packed {
        logic           vld;
        logic [CHW-1:0] ch;
    } bind_t;

    // Per-cycle update for the waiting flags
    typedef struct packed {
        logic [NCH-1:0] set;
        logic [NCH-1:0] clr;
    } pend_upd_t;

    // Lowest index whose busy bit is zero (0 when all are busy)
    function automatic logic [FW-1:0] lowest_free(input logic [NFIFO-1:0] busy);
        logic [FW-1:0] r;
        r = '0;
        for (int i = NFIFO - 1; i >= 0; i--) begin
            if (!busy[i]) r = FW'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/dtrk_pend.sv
module dtrk_pend
    import dma_trk_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] sw_req,
    input  logic [NCH-1:0] hw_req,
    input  logic [NCH-1:0] sw_en,
    input  logic [NCH-1:0] hw_en,
    input  logic [NCH-1:0] ttype,
    input  logic [NCH-1:0] frame_done,
    input  logic [NCH-1:0] block_done,
    input  logic [NCH-1:0] pkt_wr,
    input  logic [NCH-1:0] bus_err,
    input  logic [NCH-1:0] par_err,
    output logic [NCH-1:0] pend
);

    pend_upd_t      upd;
    logic [NCH-1:0] done_sel;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign done_sel[g] = (ttype_e'(ttype[g]) == TT_BLOCK) ? block_done[g]
                                                               : frame_done[g];
        assign upd.set[g]  = (sw_req[g] & sw_en[g]) | (hw_req[g] & hw_en[g]);
        assign upd.clr[g]  = done_sel[g] | pkt_wr[g] | bus_err[g] | par_err[g];
    end

    // Clear takes priority over a same-cycle set
    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend | upd.set) & ~upd.clr;
    end

endmodule

// File: rtl/dtrk_bind.sv
module dtrk_bind
    import dma_trk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             asg_valid,
    input  logic [CHW-1:0]   asg_chan,
    input  logic             halt,
    input  logic [NFIFO-1:0] rel,
    output logic [NCH-1:0]   stat,
    output logic             reject
);

    bind_t           slot [NFIFO];
    logic [NFIFO-1:0] busy;
    logic             dup;
    logic             full;
    logic             take;
    logic [FW-1:0]    pick;

    always_comb begin
        dup = 1'b0;
        for (int f = 0; f < NFIFO; f++) begin
            busy[f] = slot[f].vld;
            if (slot[f].vld && slot[f].ch == asg_chan) dup = 1'b1;
        end
        full = &busy;
        pick = lowest_free(busy);
        take = asg_valid & ~halt & ~full & ~dup;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int f = 0; f < NFIFO; f++) slot[f] <= '0;
            reject <= 1'b0;
        end else begin
            for (int f = 0; f < NFIFO; f++) begin
                if (rel[f]) slot[f].vld <= 1'b0;
                if (take && pick == FW'(f)) slot[f] <= '{vld: 1'b1, ch: asg_chan};
            end
            reject <= asg_valid & ~halt & full & ~dup;
        end
    end

    always_comb begin
        stat = '0;
        for (int f = 0; f < NFIFO; f++) begin
            if (slot[f].vld) stat[slot[f].ch] = 1'b1;
        end
    end

endmodule

// File: rtl/dma_chan_track.sv
module dma_chan_track
    import dma_trk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NCH-1:0]   sw_req,
    input  logic [NCH-1:0]   hw_req,
    input  logic [NCH-1:0]   sw_en,
    input  logic [NCH-1:0]   hw_en,
    input  logic [NCH-1:0]   ttype,
    input  logic [NCH-1:0]   frame_done,
    input  logic [NCH-1:0]   block_done,
    input  logic [NCH-1:0]   pkt_wr,
    input  logic [NCH-1:0]   bus_err,
    input  logic [NCH-1:0]   par_err,
    input  logic             glb_en,
    input  logic             emu_mode,
    input  logic             asg_valid,
    input  logic [CHW-1:0]   asg_chan,
    input  logic [NFIFO-1:0] rel,
    output logic [NCH-1:0]   pend_word,
    output logic [NCH-1:0]   stat_word,
    output logic             assign_reject
);

    logic halt;
    assign halt = ~glb_en | emu_mode;

    dtrk_pend pend_i (
        .clk        (clk),
        .rst        (rst),
        .sw_req     (sw_req),
        .hw_req     (hw_req),
        .sw_en      (sw_en),
        .hw_en      (hw_en),
        .ttype      (ttype),
        .frame_done (frame_done),
        .block_done (block_done),
        .pkt_wr     (pkt_wr),
        .bus_err    (bus_err),
        .par_err    (par_err),
        .pend       (pend_word)
    );

    dtrk_bind bind_i (
        .clk       (clk),
        .rst       (rst),
        .asg_valid (asg_valid),
        .asg_chan  (asg_chan),
        .halt      (halt),
        .rel       (rel),
        .stat      (stat_word),
        .reject    (assign_reject)
    );

endmodule

// File: rtl/dma_chan_track_chk.sv
module dma_chan_track_chk
    import dma_trk_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [NCH-1:0]   sw_req,
    input logic [NCH-1:0]   hw_req,
    input logic [NCH-1:0]   sw_en,
    input logic [NCH-1:0]   hw_en,
    input logic [NCH-1:0]   frame_done,
    input logic [NCH-1:0]   block_done,
    input logic [NCH-1:0]   pkt_wr,
    input logic [NCH-1:0]   bus_err,
    input logic [NCH-1:0]   par_err,
    input logic             glb_en,
    input logic             emu_mode,
    input logic [NFIFO-1:0] rel,
    input logic [NCH-1:0]   pend_word,
    input logic [NCH-1:0]   stat_word,
    input logic             assign_reject
);

    logic [NCH-1:0] req_e;
    logic [NCH-1:0] any_clr;
    logic [NCH-1:0] hard_clr;
    logic [NCH-1:0] req_ok;
    logic [NCH-1:0] keep;

    assign req_e    = (sw_req & sw_en) | (hw_req & hw_en);
    assign hard_clr = pkt_wr | bus_err | par_err;
    assign any_clr  = hard_clr | frame_done | block_done;
    assign req_ok   = req_e & ~any_clr;
    assign keep     = pend_word & ~any_clr;

    // R2: enabled request with no clear event sets its flag
    assert_req_sets_R2: assert property (@(posedge clk) disable iff (rst)
        (|req_ok) |=> ((pend_word & $past(req_ok)) == $past(req_ok)));

    // R3: a set flag with no clear event stays set
    assert_pend_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (|keep) |=> ((pend_word & $past(keep)) == $past(keep)));

    // R7: packet write or error always wins, request or not
    assert_clear_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (|hard_clr) |=> ((pend_word & $past(hard_clr)) == '0));

    // R9: never more than one status bit per FIFO
    assert_max_active_R9: assert property (@(posedge clk) disable iff (rst)
        $countones(stat_word) <= NFIFO);

    // R9: a reject only follows a cycle where every FIFO was busy
    assert_reject_full_R9: assert property (@(posedge clk) disable iff (rst)
        assign_reject |-> ($countones($past(stat_word)) == NFIFO));

    // R11: halted with no release, status holds
    assert_halt_hold_R11: assert property (@(posedge clk) disable iff (rst)
        ((!glb_en || emu_mode) && rel == '0) |=> (stat_word == $past(stat_word)));

endmodule

bind dma_chan_track dma_chan_track_chk chk_i (.*);

// File: tb/dma_chan_track_tb_top.sv
`timescale 1ns/1ps
module dma_chan_track_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] sw_req, hw_req, sw_en, hw_en, ttype;
    logic [31:0] frame_done, block_done, pkt_wr, bus_err, par_err;
    logic        glb_en, emu_mode, asg_valid;
    logic [4:0]  asg_chan;
    logic [1:0]  rel;
    logic [31:0] pend_word, stat_word;
    logic        assign_reject;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    dma_chan_track dut_i (.*);

    // Entry: [15:11] channel, [10] sw_req, [9] hw_req, [8] sw_en, [7] hw_en,
    // [6] ttype, [5] frame_done, [4] block_done, [3] pkt_wr, [2] bus_err,
    // [1] par_err, [0] expected flag afterwards
    localparam logic [15:0] PVEC [18] = '{
        {5'd3,  10'b1010000000, 1'b1}, // R2 software request
        {5'd3,  10'b0000000000, 1'b1}, // R3 enables dropped, flag holds
        {5'd3,  10'b0000001000, 1'b1}, // R4 frame mode ignores block done
        {5'd3,  10'b0000010000, 1'b0}, // R4 frame mode clears on frame done
        {5'd7,  10'b0100000000, 1'b0}, // R2 hw request with enable low
        {5'd7,  10'b0101000000, 1'b1}, // R2 hw request enabled
        {5'd7,  10'b0000110000, 1'b1}, // R4 block mode ignores frame done
        {5'd7,  10'b0000101000, 1'b0}, // R4 block mode clears on block done
        {5'd0,  10'b0000000100, 1'b0}, // R5 packet write on idle channel
        {5'd0,  10'b1010000000, 1'b1}, // R2 set again
        {5'd0,  10'b0000000100, 1'b0}, // R5 packet write clears
        {5'd31, 10'b0101000000, 1'b1}, // R2
        {5'd31, 10'b0000000010, 1'b0}, // R6 bus error
        {5'd31, 10'b1010000000, 1'b1}, // R2
        {5'd31, 10'b0000000001, 1'b0}, // R6 parity error
        {5'd16, 10'b1010000001, 1'b0}, // R7 request with parity error
        {5'd16, 10'b0101010000, 1'b0}, // R7 request with frame done
        {5'd16, 10'b1111000000, 1'b1}  // R2 both sources at once
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        sw_req = '0; hw_req = '0; sw_en = '0; hw_en = '0;
        frame_done = '0; block_done = '0; pkt_wr = '0; bus_err = '0; par_err = '0;
        asg_valid = 1'b0; asg_chan = '0; rel = '0;
    endtask

    // Called at a negedge with inputs driven; returns at the next negedge
    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic do_assign(input logic [4:0] ch);
        asg_valid = 1'b1; asg_chan = ch;
        step();
    endtask

    task automatic do_release(input logic [1:0] r);
        rel = r;
        step();
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] expw;
        idle();
        ttype = '0; glb_en = 1'b1; emu_mode = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 pend reset", pend_word, 32'h0);
        check("R1 stat reset", stat_word, 32'h0);
        check("R1 reject reset", {31'h0, assign_reject}, 32'h0);

        // Waiting-flag vector walk (R2 R3 R4 R5 R6 R7)
        expw = '0;
        for (int i = 0; i < 18; i++) begin
            logic [31:0] m;
            m = 32'h1 << PVEC[i][15:11];
            sw_req     = PVEC[i][10] ? m : '0;
            hw_req     = PVEC[i][9]  ? m : '0;
            sw_en      = PVEC[i][8]  ? m : '0;
            hw_en      = PVEC[i][7]  ? m : '0;
            ttype      = PVEC[i][6]  ? m : '0;
            frame_done = PVEC[i][5]  ? m : '0;
            block_done = PVEC[i][4]  ? m : '0;
            pkt_wr     = PVEC[i][3]  ? m : '0;
            bus_err    = PVEC[i][2]  ? m : '0;
            par_err    = PVEC[i][1]  ? m : '0;
            step();
            expw[PVEC[i][15:11]] = PVEC[i][0];
            check($sformatf("R2/R3/R4/R5/R6/R7 pending vector %0d", i), pend_word, expw);
        end

        // FIFO binding
        do_assign(5'd5);
        check("R8 first assign", stat_word, 32'h0000_0020);
        do_assign(5'd9);
        check("R8 second assign", stat_word, 32'h0000_0220);
        do_assign(5'd12);
        check("R9 overflow assign ignored", stat_word, 32'h0000_0220);
        check("R9 reject raised", {31'h0, assign_reject}, 32'h1);
        step();
        check("R9 reject one cycle", {31'h0, assign_reject}, 32'h0);
        do_release(2'b01);
        check("R10 release fifo0 frees ch5", stat_word, 32'h0000_0200);
        do_assign(5'd12);
        check("R8 refill lowest free fifo", stat_word, 32'h0000_1200);
        do_release(2'b10);
        check("R10 release fifo1 frees ch9", stat_word, 32'h0000_1000);
        do_assign(5'd12);
        check("R12 duplicate assign ignored", stat_word, 32'h0000_1000);
        check("R12 duplicate no reject", {31'h0, assign_reject}, 32'h0);

        // Halt conditions
        glb_en = 1'b0;
        do_assign(5'd20);
        check("R11 disabled holds status", stat_word, 32'h0000_1000);
        check("R11 disabled no reject", {31'h0, assign_reject}, 32'h0);
        glb_en = 1'b1; emu_mode = 1'b1;
        do_assign(5'd20);
        check("R11 emulation holds status", stat_word, 32'h0000_1000);
        do_release(2'b01);
        check("R11 release honored while halted", stat_word, 32'h0);
        emu_mode = 1'b0;
        check("R3 pending untouched by FIFO traffic", pend_word, expw);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule